// File: doc/BRIEF.md
# Clock Enable Control Cell

This cell produces the active-high request that switches an external clock source on and off for the whole design. While the active-low power-on reset is held, the request stays low so that no clock runs. Because no clock exists when reset is released, the cell raises the request asynchronously from the release edge itself. Later, a shutdown request is brought into the clock domain through a synchronizer. The clock is stopped only when that synchronized request is high and every functional state machine reports that it is idle. When shutdown is removed while the clock is stopped, the falling edge again raises the request without any clock edge.

The release edges arm small request flops. Each one drives the asynchronous set of the enable flop and stays active until the enable flop acknowledges by going high. The width of the set pulse therefore follows the flop's own response rather than a fixed delay line. The same pulse clears the shutdown synchronizer, so stale samples of the old request cannot stop the clock again on restart. For test, the enable flop is muxed onto a scan clock, scan reset and scan data input, its state appears on a scan output, and the asynchronous set is held inactive.

Top module: `clk_enable_ctrl`

## Requirements
- R1: While `por_n` is low and `scan_mode` is low, `clk_en` is 0, whatever the other inputs do.
- R2: When `por_n` rises (scan mode off), `clk_en` goes to 1 with no edge on `clk`.
- R3: `shutdown` reaches the stop logic only through SYNC_STAGES flops on `clk` (default 2). With all idle flags high, `clk_en` falls at the third rising `clk` edge after `shutdown` rises. After that, no further edge changes it.
- R4: While any bit of `fsm_idle` is 0, `clk_en` stays 1 regardless of `shutdown`.
- R5: A falling edge of `shutdown` while `clk_en` is 0 sets `clk_en` to 1 with no clock edge. It also clears the synchronizer, so the restarted clock does not stop again while `shutdown` stays low.
- R6: A falling edge of `shutdown` while `clk_en` is 1 leaves `clk_en` at 1, and the block keeps running.
- R7: Reset wins over set. A falling edge of `shutdown` while `por_n` is low leaves `clk_en` at 0.
- R8: With `scan_mode` high, the enable flop is reset by `scan_rst_n` low and captures `scan_in` on each rising `scan_clk` edge. `scan_out` shows its state.
- R9: With `scan_mode` high, edges on `shutdown` and `por_n` do not change `scan_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock from the external source (runs only while enabled) |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| shutdown | input | 1 | Asynchronous active-high request to stop the clock |
| fsm_idle | input | NUM_FSM | One idle/done flag per functional state machine |
| scan_mode | input | 1 | Selects scan operation of the enable flop |
| scan_clk | input | 1 | Scan shift clock |
| scan_rst_n | input | 1 | Active-low scan reset |
| scan_in | input | 1 | Scan data input |
| scan_out | output | 1 | Scan data output (enable flop state) |
| clk_en | output | 1 | Active-high enable request to the external clock source |

## Verification
The clock in the bench is gated by `clk_en` in the same way an external source would gate it, so the release cases show that the request rises with no edge at all. Shutdown is tried with one idle flag low, which must keep the clock running, and with all flags high, which must stop it on exactly the third edge. A release of shutdown is tried in three states: with the clock stopped (restart, and no second stop), with the clock still running (no effect), and during reset (reset wins). A scan shift pattern with mixed ones and zeros separates a flop that follows scan data from one that follows the functional path. Release edges applied in scan mode show whether the set input leaks through.

// File: rtl/cen_pkg.sv
`timescale 1ns/1ps
package cen_pkg;
  // default number of state machines reporting idle
  parameter int unsigned CEN_NUM_FSM    = 4;
  // default synchronizer depth for the shutdown request
  parameter int unsigned CEN_SYNC_DEPTH = 2;
endpackage

// File: rtl/cen_sync.sv
`timescale 1ns/1ps
module cen_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic din,
  output logic dout
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] stg;

  // asynchronous clear: reset and every release pulse flush stale samples
  always_ff @(posedge clk or posedge clr) begin
    if (clr) stg <= '0;
    else     stg <= {stg[LAST-1:0], din};
  end

  assign dout = stg[LAST];
endmodule

// File: rtl/cen_release_arm.sv
`timescale 1ns/1ps
module cen_release_arm #(
  parameter bit ON_RISE = 1'b1
) (
  input  logic src,
  input  logic ack,
  input  logic kill_n,
  output logic req
);
  // The request is armed by the release edge of src and withdrawn as soon as
  // the enable flop acknowledges, so the set pulse lasts exactly as long as
  // the flop needs to respond.
  generate
    if (ON_RISE) begin : g_rise
      always_ff @(posedge src or posedge ack or negedge kill_n) begin
        if (!kill_n)  req <= 1'b0;
        else if (ack) req <= 1'b0;
        else          req <= 1'b1;
      end
    end else begin : g_fall
      always_ff @(negedge src or posedge ack or negedge kill_n) begin
        if (!kill_n)  req <= 1'b0;
        else if (ack) req <= 1'b0;
        else          req <= 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/cen_enable_flop.sv
`timescale 1ns/1ps
module cen_enable_flop (
  input  logic clk,
  input  logic por_n,
  input  logic scan_mode,
  input  logic scan_clk,
  input  logic scan_rst_n,
  input  logic scan_in,
  input  logic set_act,
  input  logic stop_req,
  output logic q
);
  logic fclk;
  logic frst_n;
  logic d;

  assign fclk   = scan_mode ? scan_clk   : clk;
  assign frst_n = scan_mode ? scan_rst_n : por_n;
  // once low the functional path holds low; only a set pulse raises it
  assign d      = scan_mode ? scan_in    : (q & ~stop_req);

  // clear has priority over set
  always_ff @(posedge fclk or negedge frst_n or posedge set_act) begin
    if (!frst_n)      q <= 1'b0;
    else if (set_act) q <= 1'b1;
    else              q <= d;
  end

  // R8
  scan_shift_chk: assert property (@(posedge scan_clk)
    disable iff (!scan_mode || !scan_rst_n)
    ($past(scan_mode) && $past(scan_rst_n)) |-> (q == $past(scan_in)))
    else $error("scan capture mismatch");
endmodule

// File: rtl/clk_enable_ctrl.sv
`timescale 1ns/1ps
module clk_enable_ctrl
  import cen_pkg::*;
#(
  parameter int unsigned NUM_FSM     = CEN_NUM_FSM,
  parameter int unsigned SYNC_STAGES = CEN_SYNC_DEPTH
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               shutdown,
  input  logic [NUM_FSM-1:0] fsm_idle,
  input  logic               scan_mode,
  input  logic               scan_clk,
  input  logic               scan_rst_n,
  input  logic               scan_in,
  output logic               scan_out,
  output logic               clk_en
);
  logic en_q;
  logic req_por;
  logic req_sd;
  logic set_act;
  logic sync_clr;
  logic sd_sync;
  logic all_idle;
  logic stop_req;

  assign all_idle = &fsm_idle;
  // set input held inactive in scan mode
  assign set_act  = (req_por | req_sd) & ~scan_mode;
  assign sync_clr = set_act | ~por_n;
  assign stop_req = sd_sync & all_idle;

  cen_release_arm #(.ON_RISE(1'b1)) u_arm_por (
    .src    (por_n),
    .ack    (en_q),
    .kill_n (por_n),
    .req    (req_por)
  );

  cen_release_arm #(.ON_RISE(1'b0)) u_arm_sd (
    .src    (shutdown),
    .ack    (en_q),
    .kill_n (por_n),
    .req    (req_sd)
  );

  cen_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .clr  (sync_clr),
    .din  (shutdown),
    .dout (sd_sync)
  );

  cen_enable_flop u_flop (
    .clk        (clk),
    .por_n      (por_n),
    .scan_mode  (scan_mode),
    .scan_clk   (scan_clk),
    .scan_rst_n (scan_rst_n),
    .scan_in    (scan_in),
    .set_act    (set_act),
    .stop_req   (stop_req),
    .q          (en_q)
  );

  assign clk_en   = en_q;
  assign scan_out = en_q;

  // R4
  hold_busy_chk: assert property (@(posedge clk)
    disable iff (!por_n || scan_mode)
    (clk_en && !all_idle) |=> clk_en)
    else $error("clock stopped while a state machine was busy");

  // R3
  stop_gate_chk: assert property (@(posedge clk)
    disable iff (!por_n || scan_mode)
    (clk_en && !sd_sync) |=> clk_en)
    else $error("clock stopped without synchronized request");

  generate
    if (SYNC_STAGES == 2) begin : g_sync_chk
      // R3
      sync_path_chk: assert property (@(posedge clk)
        disable iff (!por_n || scan_mode)
        $rose(sd_sync) |-> $past(shutdown, 2))
        else $error("synchronizer output rose without matching input");
    end
  endgenerate
endmodule

// File: tb/test_clk_enable_ctrl.sv
`timescale 1ns/1ps
module test_clk_enable_ctrl;
  logic       clk_src = 1'b0;
  logic       en_l    = 1'b0;
  logic       clk_dut;
  logic       por_n   = 1'b1;
  logic       shutdown = 1'b0;
  logic [3:0] fsm_idle = 4'hF;
  logic       scan_mode = 1'b0;
  logic       scan_clk  = 1'b0;
  logic       scan_rst_n = 1'b1;
  logic       scan_in   = 1'b0;
  logic       scan_out;
  logic       clk_en;

  int n_total = 0;
  int n_fail  = 0;
  int dut_edges = 0;
  bit model_on = 1'b0;
  bit exp_en = 1'b0;
  bit m_s0 = 1'b0;
  bit m_s1 = 1'b0;
  bit done = 1'b0;

  always #2.5 clk_src = ~clk_src;
  // external source: enable latched while the source clock is low
  always @(negedge clk_src) en_l <= clk_en;
  assign clk_dut = clk_src & en_l;

  clk_enable_ctrl #(.NUM_FSM(4), .SYNC_STAGES(2)) i_clk_enable_ctrl (
    .clk        (clk_dut),
    .por_n      (por_n),
    .shutdown   (shutdown),
    .fsm_idle   (fsm_idle),
    .scan_mode  (scan_mode),
    .scan_clk   (scan_clk),
    .scan_rst_n (scan_rst_n),
    .scan_in    (scan_in),
    .scan_out   (scan_out),
    .clk_en     (clk_en)
  );

  task automatic check(input bit ok, input string req, input logic act, input logic exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: two-sample pipeline and enable state
  always @(posedge clk_dut) begin
    dut_edges++;
    if (model_on && por_n) begin
      if (exp_en && m_s1 && (&fsm_idle)) exp_en = 1'b0;
      m_s1 = m_s0;
      m_s0 = shutdown;
    end
  end

  // R3 R4 cycle compare
  always @(negedge clk_src) begin
    if (model_on && !done)
      check(clk_en === exp_en, "R3 model", clk_en, exp_en);
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk_src);
    #1;
  endtask

  task automatic drop_shutdown();
    shutdown = 1'b0;
    if (model_on && por_n && !exp_en) begin
      exp_en = 1'b1; m_s0 = 1'b0; m_s1 = 1'b0;
    end
  endtask

  task automatic por_cycle();
    int e0;
    model_on = 1'b0;
    por_n = 1'b0;
    #1;
    check(clk_en === 1'b0, "R1 reset low", clk_en, 1'b0);
    step(3);
    e0 = dut_edges;
    exp_en = 1'b1; m_s0 = 1'b0; m_s1 = 1'b0;
    por_n = 1'b1;
    #1;
    check(clk_en === 1'b1, "R2 release sets", clk_en, 1'b1);
    check(dut_edges == e0, "R2 no clock edge", logic'(dut_edges != e0), 1'b0);
    model_on = 1'b1;
  endtask

  initial begin
    int e0;
    int e_stop;
    bit pat [4] = '{1'b1, 1'b0, 1'b1, 1'b1};
    #1 por_n = 1'b0;
    #4;
    check(clk_en === 1'b0, "R1 initial", clk_en, 1'b0);
    // R7: shutdown released during reset
    shutdown = 1'b1; #3; shutdown = 1'b0; #2;
    check(clk_en === 1'b0, "R7 reset wins", clk_en, 1'b0);
    step(1);
    e0 = dut_edges;
    exp_en = 1'b1;
    por_n = 1'b1;
    #1;
    check(clk_en === 1'b1, "R2 release sets", clk_en, 1'b1);
    check(dut_edges == e0, "R2 no clock edge", logic'(dut_edges != e0), 1'b0);
    model_on = 1'b1;
    step(4);

    // R4: one machine busy
    fsm_idle = 4'b1011;
    shutdown = 1'b1;
    step(12);
    check(clk_en === 1'b1, "R4 busy holds", clk_en, 1'b1);
    fsm_idle = 4'b0111;
    step(6);
    check(clk_en === 1'b1, "R4 other busy holds", clk_en, 1'b1);

    // R6: release while still running
    drop_shutdown();
    step(1);
    check(clk_en === 1'b1, "R6 release while running", clk_en, 1'b1);
    step(5);
    check(clk_en === 1'b1, "R6 still running", clk_en, 1'b1);

    // R3: all idle, stop on third edge
    fsm_idle = 4'hF;
    e0 = dut_edges;
    shutdown = 1'b1;
    e_stop = -1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_src);
      if (clk_en === 1'b0 && e_stop < 0) e_stop = dut_edges - e0;
    end
    check(e_stop == 3, "R3 stop edge", logic'(e_stop == 3), 1'b1);
    e0 = dut_edges;
    step(10);
    check(dut_edges == e0, "R3 clock stays off", logic'(dut_edges != e0), 1'b0);
    check(clk_en === 1'b0, "R3 stays low", clk_en, 1'b0);

    // R5: release restarts without clock
    e0 = dut_edges;
    drop_shutdown();
    #1;
    check(clk_en === 1'b1, "R5 restart", clk_en, 1'b1);
    check(dut_edges == e0, "R5 no clock edge", logic'(dut_edges != e0), 1'b0);
    step(10);
    check(clk_en === 1'b1, "R5 no second stop", clk_en, 1'b1);

    // R1: reset in operation
    step(1);
    model_on = 1'b0;
    por_n = 1'b0;
    #1;
    check(clk_en === 1'b0, "R1 reset mid-run", clk_en, 1'b0);
    shutdown = 1'b1;
    step(2);
    check(clk_en === 1'b0, "R1 reset holds", clk_en, 1'b0);
    shutdown = 1'b0;
    step(1);
    check(clk_en === 1'b0, "R7 reset wins again", clk_en, 1'b0);
    por_cycle();
    step(3);

    // R8: scan reset and shift
    model_on = 1'b0;
    scan_mode = 1'b1;
    #1;
    scan_rst_n = 1'b0;
    #1;
    check(scan_out === 1'b0, "R8 scan reset", scan_out, 1'b0);
    scan_rst_n = 1'b1;
    #1;
    foreach (pat[i]) begin
      scan_in = pat[i];
      #2 scan_clk = 1'b1;
      #2 scan_clk = 1'b0;
      #1;
      check(scan_out === pat[i], "R8 scan shift", scan_out, pat[i]);
    end
    scan_in = 1'b0;
    #2 scan_clk = 1'b1;
    #2 scan_clk = 1'b0;
    #1;
    check(scan_out === 1'b0, "R8 scan shift zero", scan_out, 1'b0);

    // R9: release edges inert in scan mode
    shutdown = 1'b1; #4; shutdown = 1'b0; #4;
    check(scan_out === 1'b0, "R9 shutdown edge", scan_out, 1'b0);
    por_n = 1'b0; #4; por_n = 1'b1; #4;
    check(scan_out === 1'b0, "R9 reset edge", scan_out, 1'b0);

    // back to function
    step(1);
    scan_mode = 1'b0;
    por_cycle();
    step(5);
    check(clk_en === 1'b1, "R2 running after scan", clk_en, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule